// File: doc/BRIEF.md
# Address-Triggered Cartridge Bank Latch

This block selects which slice of a large external ROM a multi-game cartridge shows to a 13-bit 6502-family bus. The cartridge port has no write strobe, so the bank number travels in the address. Any qualified bus access that lands in a reserved control window copies the low address bits into a control register. Plain reads count, because the block has no data bus input. The register holds a bank number, a flag that picks 2K or 4K mapping, and a lock flag that freezes the register against later window accesses.

From that register and the live CPU address, the block forms the upper ROM address lines and the ROM chip enable. One active-low reset input serves both power-up and a return-to-menu push button. Asserting it clears the register at once. Its release is synchronised to the clock. A parameter selects a reduced build that decodes a narrower window and keeps eight control bits instead of eleven.

Top module: `cart_bank_latch`

## Requirements
- R1: A control access is a clock edge with `bus_strobe`=1 and `bus_addr[12]`=0, `bus_addr[11]`=1. The reduced build (`FULL_DECODE`=0) also requires `bus_addr[10:8]`=0, which confines its window to 0x0800–0x08FF.
- R2: A strobed access outside the control window leaves the register unchanged. This covers any access with `bus_addr[12]`=1 or `bus_addr[11]`=0.
- R3: Full build: an unlocked control access loads the bank from `bus_addr[8:0]`, the mode from `bus_addr[9]` (1 = 4K) and the lock from `bus_addr[10]`. The new bank is visible on `rom_addr` from the cycle after the strobe edge.
- R4: In 2K mode, `rom_addr` = bank*2048 + (`bus_addr` mod 2048), so 0x1000–0x17FF and 0x1800–0x1FFF show the same 2K.
- R5: In 4K mode, `rom_addr` = (bank/2)*4096 + (`bus_addr` mod 4096). The bank's low bit is dropped and `bus_addr[11]` takes its place.
- R6: A control access with the lock bit set still loads all fields. After that, every control access is ignored until reset.
- R7: Reset asserted (`rst_n`=0) clears the register at once: bank 0, 2K mode, unlocked. Release takes effect after two rising clock edges.
- R8: `rom_ce` equals `bus_addr[12]`.
- R9: A window address presented without `bus_strobe` changes nothing.
- R10: Reduced build: the bank comes from `bus_addr[5:0]`, the mode from `bus_addr[6]` and the lock from `bus_addr[7]`. `rom_addr` is 17 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset (power-up and return-to-menu), asynchronous assert |
| bus_strobe | input | 1 | One-cycle qualifier, high once per CPU bus cycle with a stable address |
| bus_addr | input | 13 | CPU address |
| rom_addr | output | 20 (17 reduced) | External ROM address |
| rom_ce | output | 1 | External ROM chip enable, active high |

## Verification
The assertions assume that `bus_strobe` marks a cycle in which `bus_addr` is already stable. They also assume that nothing is checked while the internal reset is asserted or for the two edges before it releases. The bench therefore changes the address and strobe only on falling edges and raises the strobe for exactly one rising edge per access. After each release of reset it waits three clocks before the first access. Both builds share one bus, so a single bench model tracks what every access does to each register.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  localparam int unsigned CPU_AW  = 13;
  localparam int unsigned PAGE_W  = 11;

  typedef enum logic {
    MAP_2K = 1'b0,
    MAP_4K = 1'b1
  } map_mode_e;

  function automatic int unsigned ctrl_bits(input bit full_decode);
    return full_decode ? 11 : 8;
  endfunction

endpackage

// File: rtl/cbl_reset_sync.sv
module cbl_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/cbl_window_decode.sv
module cbl_window_decode
  import cart_bank_pkg::*;
#(
  parameter bit          FULL_DECODE = 1'b1,
  parameter int unsigned CTRL_W      = 11
) (
  input  logic              bus_strobe,
  input  logic [CPU_AW-1:0] bus_addr,
  output logic              load_req,
  output logic [CTRL_W-1:0] ctrl_field
);

  logic coarse_hit;
  logic fine_hit;

  assign coarse_hit = ~bus_addr[12] & bus_addr[11];

  generate
    if (FULL_DECODE) begin : g_full
      assign fine_hit = 1'b1;
    end else begin : g_reduced
      assign fine_hit = (bus_addr[10:8] == 3'b000);
    end
  endgenerate

  assign load_req   = bus_strobe & coarse_hit & fine_hit;
  assign ctrl_field = bus_addr[CTRL_W-1:0];

endmodule

// File: rtl/cbl_ctrl_reg.sv
module cbl_ctrl_reg
  import cart_bank_pkg::*;
#(
  parameter int unsigned CTRL_W = 11,
  localparam int unsigned BANK_W   = CTRL_W - 2,
  localparam int unsigned MODE_IDX = CTRL_W - 2,
  localparam int unsigned LOCK_IDX = CTRL_W - 1
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              load_req,
  input  logic [CTRL_W-1:0] ctrl_field,
  output logic [BANK_W-1:0] bank_q,
  output map_mode_e         mode_q,
  output logic              lock_q
);

  logic              load_en;
  logic [BANK_W-1:0] bank_d;
  map_mode_e         mode_d;
  logic              lock_d;

  always_comb begin
    load_en = load_req & ~lock_q;
    bank_d  = ctrl_field[BANK_W-1:0];
    mode_d  = map_mode_e'(ctrl_field[MODE_IDX]);
    lock_d  = ctrl_field[LOCK_IDX];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      bank_q <= '0;
      mode_q <= MAP_2K;
      lock_q <= 1'b0;
    end else if (load_en) begin
      bank_q <= bank_d;
      mode_q <= mode_d;
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/cbl_rom_map.sv
module cbl_rom_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned BANK_W = 9,
  localparam int unsigned ROM_AW = BANK_W + PAGE_W
) (
  input  logic [CPU_AW-1:0] bus_addr,
  input  logic [BANK_W-1:0] bank_q,
  input  map_mode_e         mode_q,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce
);

  always_comb begin
    if (mode_q == MAP_4K) begin
      rom_addr = {bank_q[BANK_W-1:1], bus_addr[PAGE_W], bus_addr[PAGE_W-1:0]};
    end else begin
      rom_addr = {bank_q, bus_addr[PAGE_W-1:0]};
    end
    rom_ce = bus_addr[12];
  end

endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
  import cart_bank_pkg::*;
#(
  parameter bit FULL_DECODE = 1'b1,
  localparam int unsigned CTRL_W = ctrl_bits(FULL_DECODE),
  localparam int unsigned BANK_W = CTRL_W - 2,
  localparam int unsigned ROM_AW = BANK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic [CPU_AW-1:0] bus_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce
);

  logic              rst_core_n;
  logic              load_req;
  logic [CTRL_W-1:0] ctrl_field;
  logic [BANK_W-1:0] bank_q;
  map_mode_e         mode_q;
  logic              lock_q;

  cbl_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  cbl_window_decode #(.FULL_DECODE(FULL_DECODE), .CTRL_W(CTRL_W)) u_dec (
    .bus_strobe (bus_strobe),
    .bus_addr   (bus_addr),
    .load_req   (load_req),
    .ctrl_field (ctrl_field)
  );

  cbl_ctrl_reg #(.CTRL_W(CTRL_W)) u_reg (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .load_req   (load_req),
    .ctrl_field (ctrl_field),
    .bank_q     (bank_q),
    .mode_q     (mode_q),
    .lock_q     (lock_q)
  );

  cbl_rom_map #(.BANK_W(BANK_W)) u_map (
    .bus_addr (bus_addr),
    .bank_q   (bank_q),
    .mode_q   (mode_q),
    .rom_addr (rom_addr),
    .rom_ce   (rom_ce)
  );

endmodule

// File: rtl/cart_bank_latch_chk.sv
module cart_bank_latch_chk
  import cart_bank_pkg::*;
#(
  parameter bit FULL_DECODE = 1'b1,
  localparam int unsigned CTRL_W = ctrl_bits(FULL_DECODE),
  localparam int unsigned BANK_W = CTRL_W - 2,
  localparam int unsigned ROM_AW = BANK_W + PAGE_W
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_strobe,
  input logic [CPU_AW-1:0] bus_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [BANK_W-1:0] bank_q,
  input map_mode_e         mode_q,
  input logic              lock_q
);

  logic in_window;
  assign in_window = ~bus_addr[12] & bus_addr[11] &
                     (FULL_DECODE ? 1'b1 : (bus_addr[10:8] == 3'b000));

  always @(posedge clk) begin
    if (!rst_core_n) begin
      AST_RESET_CLEARS: assert (bank_q == '0 && mode_q == MAP_2K && !lock_q); // R7
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    lock_q |=> lock_q); // R6

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    lock_q |=> ($stable(bank_q) && $stable(mode_q))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_strobe |=> ($stable(bank_q) && $stable(mode_q) && $stable(lock_q))); // R9

  AST_OUTSIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_strobe && !in_window) |=> ($stable(bank_q) && $stable(mode_q) && $stable(lock_q))); // R2

  AST_CAPTURE_BANK: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_strobe && in_window && !lock_q) |=> (bank_q == $past(bus_addr[BANK_W-1:0]))); // R3

  AST_MIRROR_2K: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_q == MAP_2K) |-> (rom_addr[ROM_AW-1:PAGE_W] == bank_q)); // R4

endmodule

bind cart_bank_latch cart_bank_latch_chk #(.FULL_DECODE(FULL_DECODE)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_strobe (bus_strobe),
  .bus_addr   (bus_addr),
  .rom_addr   (rom_addr),
  .bank_q     (bank_q),
  .mode_q     (mode_q),
  .lock_q     (lock_q)
);

// File: tb/tb_cart_bank_latch.sv
module tb_cart_bank_latch;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_strobe;
  logic [12:0] bus_addr;
  logic [19:0] rom_addr_f;
  logic        rom_ce_f;
  logic [16:0] rom_addr_r;
  logic        rom_ce_r;

  int checks;
  int errors;
  int fb, fm, fl;
  int rb, rm, rl;

  cart_bank_latch #(.FULL_DECODE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .rom_addr(rom_addr_f), .rom_ce(rom_ce_f)
  );

  cart_bank_latch #(.FULL_DECODE(1'b0)) dut_r (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .rom_addr(rom_addr_r), .rom_ce(rom_ce_r)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_rom(input int bank, input int mode, input int a);
    return mode ? (bank / 2) * 4096 + (a % 4096) : bank * 2048 + (a % 2048);
  endfunction

  task automatic model_reset();
    fb = 0; fm = 0; fl = 0;
    rb = 0; rm = 0; rl = 0;
  endtask

  task automatic model_access(input int a);
    if (((a >> 12) & 1) == 0 && ((a >> 11) & 1) == 1 && fl == 0) begin
      fb = a % 512; fm = (a >> 9) & 1; fl = (a >> 10) & 1;
    end
    if (((a >> 8) & 31) == 8 && rl == 0) begin
      rb = a % 64; rm = (a >> 6) & 1; rl = (a >> 7) & 1;
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // strobed access: driven on a falling edge, captured by one rising edge
  task automatic access(input int a, input bit strobe);
    @(negedge clk);
    bus_addr   = 13'(a);
    bus_strobe = strobe;
    @(negedge clk);
    bus_strobe = 1'b0;
    if (strobe) model_access(a);
  endtask

  // presents a cartridge address with no strobe and compares both builds
  task automatic look(input string tag, input int a);
    bus_addr = 13'(a);
    #1;
    check_int({tag, " full rom_addr"}, int'(rom_addr_f), exp_rom(fb, fm, a));
    check_int({tag, " reduced rom_addr"}, int'(rom_addr_r), exp_rom(rb, rm, a));
    check_int("R8 rom_ce", int'(rom_ce_f), (a >> 12) & 1);
    check_int("R8 rom_ce reduced", int'(rom_ce_r), (a >> 12) & 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    model_reset();
    // R7: clearing is immediate, without waiting for a clock edge
    check_int("R7 async clear", int'(rom_addr_f), exp_rom(0, 0, int'(bus_addr)));
    check_int("R7 async clear reduced", int'(rom_addr_r), exp_rom(0, 0, int'(bus_addr)));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_strobe = 1'b0; bus_addr = 13'h1000;
    model_reset();
    repeat (3) @(negedge clk);
    look("R7 reset state", 13'h1234);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R3 R4 R5: every bank in both modes on the full build
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 512; b++) begin
        int off;
        access(32'h800 | (m << 9) | b, 1'b1);
        off = (b * 37 + m * 5) % 2048;
        look(m ? "R5 4K lower" : "R4 2K lower", 32'h1000 + off);
        look(m ? "R5 4K upper" : "R4 2K upper", 32'h1800 + off);
      end
    end

    // R10: reduced build sweep with its lock bit kept clear
    do_reset();
    for (int v = 0; v < 128; v++) begin
      access(32'h800 | v, 1'b1);
      look("R10 reduced sweep", 32'h1000 + ((v * 53) % 4096));
    end

    // R10 R1: reduced window excludes A10..A8 nonzero
    do_reset();
    access(32'h0812, 1'b1);
    access(32'h0905, 1'b1);
    look("R10 narrow window", 32'h1800);
    check_int("R10 bank kept at 0x12", int'(rom_addr_r), 32'h12 * 2048);

    // R3: access at 0x0A05 picks bank 5 in 4K mode
    do_reset();
    access(32'h0A05, 1'b1);
    look("R3 bank5 4K", 32'h1000);
    check_int("R3 bank5 4K upper", int'(rom_addr_f), 32'd8192);
    look("R3 bank5 4K", 32'h1800);
    check_int("R3 bank5 4K upper", int'(rom_addr_f), 32'd10240);

    // R9: window address held without strobe
    access(32'h0A77, 1'b0);
    look("R9 no strobe", 32'h1555);

    // R2: strobed accesses outside the window
    access(32'h0080, 1'b1);
    access(32'h0285, 1'b1);
    access(32'h1A09, 1'b1);
    access(32'h0405, 1'b1);
    look("R2 outside window", 32'h1ABC);

    // R6: locking access loads, later window accesses ignored
    access(32'h0C07, 1'b1);
    look("R6 lock loads", 32'h1801);
    check_int("R6 lock loads bank 7 2K", int'(rom_addr_f), 7 * 2048 + 1);
    access(32'h0A09, 1'b1);
    access(32'h0B33, 1'b1);
    look("R6 locked", 32'h1801);
    check_int("R6 still bank 7", int'(rom_addr_f), 7 * 2048 + 1);

    // R7: reset releases the lock and restores bank 0 2K
    do_reset();
    look("R7 after reset", 32'h1FFF);
    check_int("R7 bank0 2K", int'(rom_addr_f), 32'h7FF);
    access(32'h0A05, 1'b1);
    look("R7 unlocked after reset", 32'h1000);
    check_int("R7 unlocked bank5", int'(rom_addr_f), 32'd8192);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule